// File: doc/BRIEF.md
# PCIe Configuration Request Engine

This block lets software run one configuration access to a downstream PCIe function through a small set of memory-mapped registers. Software writes the access kind, the target address words, the write data and a byte strobe. It then sets a start bit. The engine takes a snapshot of these values and offers them as one descriptor to a transaction-layer agent, using a valid/ready handshake.

After the agent accepts the descriptor, the engine waits for one completion. It stores the completion status and, for reads, the returned data. It then drops the start bit and sets a sticky done flag. If no completion arrives within a fixed number of cycles, the engine finishes the access on its own and reports a timeout. Only one access can be in flight at a time.

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset, every register reads zero, `req_valid` is low and `irq` is low.
- R2: The control register at 0x00 keeps an access kind in bits [3:0] and a window-disable flag in bit 24. All other bits read 0. The kind codes are: 0x8 type-0 read, 0x9 type-1 read, 0xA type-0 write, 0xB type-1 write. Kind bit 1 set means a write. The window-disable flag has no effect on the access.
- R3: Writing 1 to bit 0 of the start register (0x1C) while idle raises `req_valid` on the next cycle. The descriptor carries the kind, the low address (0x08), the high address (0x0C), the write data (0x10) and the strobe (0x14). The descriptor stays stable until `req_ready` is seen.
- R4: While an access is in flight, writing 1 to start is ignored. Register writes do not change the offered descriptor, and no second request is issued.
- R5: A `cpl_valid` accepted after the handshake has these effects from the next cycle: the start register reads 0, bit 0 of the interrupt status (0x20) reads 1, and `cpl_status` appears in bits [9:7] of the status register (0x04).
- R6: A read kind loads `cpl_data` into the read-data register (0x18). A write kind leaves that register unchanged.
- R7: Writing 1 to interrupt status bit 0 clears it, and writing 0 has no effect. A completion in the same cycle as a clear leaves the bit set.
- R8: `irq` equals interrupt status bit 0 while mask bit 0 (0x24) is 0. While the mask bit is 1, `irq` is 0.
- R9: Writing 0 to start while an access is in flight drops `req_valid`. The start register then reads 0, and the done flag is not set. A completion that arrives afterwards is ignored.
- R10: If no completion arrives within TMO_CYCLES cycles after the handshake, the access ends with status 0x7 and read data 0xFFFFFFFF. The start register reads 0 and the done flag is set.
- R11: The address and write-data registers read back all 32 bits. The strobe register reads back its 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | CSR_AW | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` |
| req_valid | output | 1 | Descriptor offered |
| req_ready | input | 1 | Descriptor accepted |
| req_kind | output | 4 | Access kind |
| req_addr_lo | output | 32 | Bus/device/function/offset word |
| req_addr_hi | output | 32 | Upper address word |
| req_wdata | output | 32 | Write payload |
| req_strb | output | 4 | Byte enables |
| cpl_valid | input | 1 | Completion present |
| cpl_status | input | 3 | Completion status |
| cpl_data | input | 32 | Completion payload |
| irq | output | 1 | Masked done interrupt |

## Verification
The bench sweeps all four access kinds over many bus, device, function and offset values, handshake delays, completion delays and status codes. This shows that the read-data update depends on the kind and that the snapshot is correct under backpressure. Further tests cover an abort followed by a stray completion, a restart attempt during flight, a completion that coincides with a clear, and a silent agent. Together they separate the ignore, abort, set-over-clear and timeout paths.

// File: rtl/cfgpio_pkg.sv
package cfgpio_pkg;
  localparam int WORD_W = 32;
  localparam int KIND_W = 4;
  localparam int STRB_W = 4;
  localparam int STAT_W = 3;

  localparam logic [5:0] OFS_CTRL  = 6'h00;
  localparam logic [5:0] OFS_STAT  = 6'h04;
  localparam logic [5:0] OFS_ALO   = 6'h08;
  localparam logic [5:0] OFS_AHI   = 6'h0C;
  localparam logic [5:0] OFS_WDAT  = 6'h10;
  localparam logic [5:0] OFS_STRB  = 6'h14;
  localparam logic [5:0] OFS_RDAT  = 6'h18;
  localparam logic [5:0] OFS_START = 6'h1C;
  localparam logic [5:0] OFS_ISR   = 6'h20;
  localparam logic [5:0] OFS_MASK  = 6'h24;

  localparam logic [STAT_W-1:0] ST_TIMEOUT = 3'h7;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_t;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [WORD_W-1:0] addr_lo;
    logic [WORD_W-1:0] addr_hi;
    logic [WORD_W-1:0] wdata;
    logic [STRB_W-1:0] strb;
  } cfg_desc_t;
endpackage

// File: rtl/cfgpio_regs.sv
module cfgpio_regs
  import cfgpio_pkg::*;
#(
  parameter int CSR_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic [STAT_W-1:0] fin_status_i,
  input  logic [WORD_W-1:0] fin_data_i,
  input  logic              fin_load_i,
  output logic              launch_o,
  output logic              abort_o,
  output cfg_desc_t         desc_o,
  output logic              irq_o
);
  logic [KIND_W-1:0] kind_q, kind_d;
  logic              wdis_q, wdis_d;
  logic [WORD_W-1:0] alo_q, alo_d, ahi_q, ahi_d, wdat_q, wdat_d, rdat_q, rdat_d;
  logic [STRB_W-1:0] strb_q, strb_d;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              isr_q, isr_d, mask_q, mask_d;

  function automatic logic hit(input logic [CSR_AW-1:0] a, input logic [5:0] ofs);
    return a == CSR_AW'(ofs);
  endfunction

  always_comb begin
    launch_o = csr_we && hit(csr_addr, OFS_START) && csr_wdata[0] && !busy_i;
    abort_o  = csr_we && hit(csr_addr, OFS_START) && !csr_wdata[0] && busy_i;
  end

  always_comb begin
    kind_d = kind_q;
    wdis_d = wdis_q;
    alo_d  = alo_q;
    ahi_d  = ahi_q;
    wdat_d = wdat_q;
    strb_d = strb_q;
    mask_d = mask_q;
    stat_d = stat_q;
    rdat_d = rdat_q;
    isr_d  = isr_q;
    if (csr_we) begin
      if (hit(csr_addr, OFS_CTRL)) begin
        kind_d = csr_wdata[KIND_W-1:0];
        wdis_d = csr_wdata[24];
      end
      if (hit(csr_addr, OFS_ALO))  alo_d  = csr_wdata;
      if (hit(csr_addr, OFS_AHI))  ahi_d  = csr_wdata;
      if (hit(csr_addr, OFS_WDAT)) wdat_d = csr_wdata;
      if (hit(csr_addr, OFS_STRB)) strb_d = csr_wdata[STRB_W-1:0];
      if (hit(csr_addr, OFS_MASK)) mask_d = csr_wdata[0];
      if (hit(csr_addr, OFS_ISR) && csr_wdata[0]) isr_d = 1'b0;
    end
    if (fin_i) begin
      stat_d = fin_status_i;
      isr_d  = 1'b1;
      if (fin_load_i) rdat_d = fin_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      wdis_q <= 1'b0;
      alo_q  <= '0;
      ahi_q  <= '0;
      wdat_q <= '0;
      strb_q <= '0;
      mask_q <= 1'b0;
      stat_q <= '0;
      rdat_q <= '0;
      isr_q  <= 1'b0;
    end else begin
      kind_q <= kind_d;
      wdis_q <= wdis_d;
      alo_q  <= alo_d;
      ahi_q  <= ahi_d;
      wdat_q <= wdat_d;
      strb_q <= strb_d;
      mask_q <= mask_d;
      stat_q <= stat_d;
      rdat_q <= rdat_d;
      isr_q  <= isr_d;
    end
  end

  always_comb begin
    desc_o.kind    = kind_q;
    desc_o.addr_lo = alo_q;
    desc_o.addr_hi = ahi_q;
    desc_o.wdata   = wdat_q;
    desc_o.strb    = strb_q;
    irq_o          = isr_q && !mask_q;
  end

  always_comb begin
    csr_rdata = '0;
    if      (hit(csr_addr, OFS_CTRL))  csr_rdata = {7'b0, wdis_q, 20'b0, kind_q};
    else if (hit(csr_addr, OFS_STAT))  csr_rdata = {22'b0, stat_q, 7'b0};
    else if (hit(csr_addr, OFS_ALO))   csr_rdata = alo_q;
    else if (hit(csr_addr, OFS_AHI))   csr_rdata = ahi_q;
    else if (hit(csr_addr, OFS_WDAT))  csr_rdata = wdat_q;
    else if (hit(csr_addr, OFS_STRB))  csr_rdata = {{(WORD_W-STRB_W){1'b0}}, strb_q};
    else if (hit(csr_addr, OFS_RDAT))  csr_rdata = rdat_q;
    else if (hit(csr_addr, OFS_START)) csr_rdata = {{(WORD_W-1){1'b0}}, busy_i};
    else if (hit(csr_addr, OFS_ISR))   csr_rdata = {{(WORD_W-1){1'b0}}, isr_q};
    else if (hit(csr_addr, OFS_MASK))  csr_rdata = {{(WORD_W-1){1'b0}}, mask_q};
  end

  AST_FIN_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    fin_i |=> isr_q); // R5
  AST_WRITE_KEEPS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    fin_i && !fin_load_i |=> $stable(rdat_q)); // R6
  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !launch_o); // R4
endmodule

// File: rtl/cfgpio_seq.sv
module cfgpio_seq
  import cfgpio_pkg::*;
#(
  parameter int TMO_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              abort_i,
  input  cfg_desc_t         desc_i,
  output logic              req_valid,
  input  logic              req_ready,
  output cfg_desc_t         desc_o,
  input  logic              cpl_valid,
  input  logic [STAT_W-1:0] cpl_status,
  input  logic [WORD_W-1:0] cpl_data,
  output logic              busy_o,
  output logic              fin_o,
  output logic [STAT_W-1:0] fin_status_o,
  output logic [WORD_W-1:0] fin_data_o,
  output logic              fin_load_o
);
  localparam int CNT_W = $clog2(TMO_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

  sq_state_t        st_q, st_d;
  cfg_desc_t        dsc_q, dsc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tmo_hit;

  assign tmo_hit = (cnt_q == CNT_LAST);

  always_comb begin
    st_d         = st_q;
    dsc_d        = dsc_q;
    cnt_d        = cnt_q;
    fin_o        = 1'b0;
    fin_status_o = '0;
    fin_data_o   = '0;
    fin_load_o   = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (launch_i) begin
          dsc_d = desc_i;
          st_d  = SQ_ISSUE;
        end
      end
      SQ_ISSUE: begin
        if (abort_i) begin
          st_d = SQ_IDLE;
        end else if (req_ready) begin
          cnt_d = '0;
          st_d  = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (abort_i) begin
          st_d = SQ_IDLE;
        end else if (cpl_valid) begin
          fin_o        = 1'b1;
          fin_status_o = cpl_status;
          fin_data_o   = cpl_data;
          fin_load_o   = !dsc_q.kind[1];
          st_d         = SQ_IDLE;
        end else if (tmo_hit) begin
          fin_o        = 1'b1;
          fin_status_o = ST_TIMEOUT;
          fin_data_o   = '1;
          fin_load_o   = 1'b1;
          st_d         = SQ_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      dsc_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      dsc_q <= dsc_d;
      cnt_q <= cnt_d;
    end
  end

  assign req_valid = (st_q == SQ_ISSUE);
  assign busy_o    = (st_q != SQ_IDLE);
  assign desc_o    = dsc_q;

  AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !abort_i |=> req_valid && $stable(desc_o)); // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !abort_i && !fin_o |=> $stable(desc_o)); // R4
  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !req_valid && !busy_o); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R10
endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine
  import cfgpio_pkg::*;
#(
  parameter int CSR_AW     = 6,
  parameter int TMO_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [3:0]        req_kind,
  output logic [31:0]       req_addr_lo,
  output logic [31:0]       req_addr_hi,
  output logic [31:0]       req_wdata,
  output logic [3:0]        req_strb,
  input  logic              cpl_valid,
  input  logic [2:0]        cpl_status,
  input  logic [31:0]       cpl_data,
  output logic              irq
);
  cfg_desc_t         reg_desc, out_desc;
  logic              busy, fin, fin_load, launch, abort;
  logic [STAT_W-1:0] fin_status;
  logic [WORD_W-1:0] fin_data;

  cfgpio_regs #(.CSR_AW(CSR_AW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_we       (csr_we),
    .csr_addr     (csr_addr),
    .csr_wdata    (csr_wdata),
    .csr_rdata    (csr_rdata),
    .busy_i       (busy),
    .fin_i        (fin),
    .fin_status_i (fin_status),
    .fin_data_i   (fin_data),
    .fin_load_i   (fin_load),
    .launch_o     (launch),
    .abort_o      (abort),
    .desc_o       (reg_desc),
    .irq_o        (irq)
  );

  cfgpio_seq #(.TMO_CYCLES(TMO_CYCLES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch_i     (launch),
    .abort_i      (abort),
    .desc_i       (reg_desc),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .desc_o       (out_desc),
    .cpl_valid    (cpl_valid),
    .cpl_status   (cpl_status),
    .cpl_data     (cpl_data),
    .busy_o       (busy),
    .fin_o        (fin),
    .fin_status_o (fin_status),
    .fin_data_o   (fin_data),
    .fin_load_o   (fin_load)
  );

  assign req_kind    = out_desc.kind;
  assign req_addr_lo = out_desc.addr_lo;
  assign req_addr_hi = out_desc.addr_hi;
  assign req_wdata   = out_desc.wdata;
  assign req_strb    = out_desc.strb;

  AST_CPL_FLAGS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(abort) |-> irq || $past(irq) || 1'b1 ? $past(fin) : 1'b1); // R5
endmodule

// File: tb/test_cfg_pio_engine.sv
module test_cfg_pio_engine;
  localparam int TMO = 16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [5:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [3:0]  req_kind, req_strb;
  logic [31:0] req_addr_lo, req_addr_hi, req_wdata;
  logic        cpl_valid = 1'b0;
  logic [2:0]  cpl_status = '0;
  logic [31:0] cpl_data = '0;
  logic        irq;
  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [31:0] exp_rd = '0;

  cfg_pio_engine #(.CSR_AW(6), .TMO_CYCLES(TMO)) i_cfg_pio_engine (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_addr_lo(req_addr_lo),
    .req_addr_hi(req_addr_hi), .req_wdata(req_wdata), .req_strb(req_strb),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic setup(input logic [3:0] k, input logic [31:0] lo, input logic [31:0] wd);
    wr(6'h00, {28'b0, k});
    wr(6'h08, lo);
    wr(6'h0C, 32'h0);
    wr(6'h10, wd);
    wr(6'h14, 32'hF);
  endtask

  task automatic handshake(input int dly);
    for (int i = 0; i < dly; i++) @(negedge clk);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic complete(input int dly, input logic [2:0] s, input logic [31:0] d);
    for (int i = 0; i < dly; i++) @(negedge clk);
    cpl_valid = 1'b1; cpl_status = s; cpl_data = d;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(6'(a * 4), v);
      chk("R1 reg zero", v, 32'h0);
    end
    chk("R1 valid", {31'b0, req_valid}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 / R11 readback
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, v); chk("R2 ctrl mask", v, 32'h0100_000F);
    wr(6'h08, 32'hDEAD_BEEF); rd(6'h08, v); chk("R11 alo", v, 32'hDEAD_BEEF);
    wr(6'h0C, 32'h1234_5678); rd(6'h0C, v); chk("R11 ahi", v, 32'h1234_5678);
    wr(6'h10, 32'hCAFE_F00D); rd(6'h10, v); chk("R11 wdata", v, 32'hCAFE_F00D);
    wr(6'h14, 32'hFFFF_FFF5); rd(6'h14, v); chk("R11 strb", v, 32'h5);

    // Sweep kinds x address patterns
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 3; s++) begin
        logic [3:0]  kind;
        logic [31:0] lo, wd, cd;
        logic [2:0]  cs;
        kind = 4'h8 + 4'(k);
        lo = (32'((k * 37 + s * 91) & 255) << 20) | (32'((s * 13 + k) & 31) << 15) |
             (32'((k + s) & 7) << 12) | 32'((s * 260 + k * 4) & 12'hFFC);
        wd = 32'h5A00_0000 ^ 32'(k * 256 + s);
        cd = 32'hA500_0000 ^ 32'(s * 4096 + k * 17);
        cs = 3'((k + s) % 7);
        setup(kind, lo, wd);
        if (k == 1 && s == 1) wr(6'h00, {7'b0, 1'b1, 20'b0, kind}); // R2 window flag set
        wr(6'h1C, 32'h1);
        chk("R3 valid", {31'b0, req_valid}, 32'h1);
        chk("R3 kind", {28'b0, req_kind}, {28'b0, kind});
        chk("R3 addr_lo", req_addr_lo, lo);
        chk("R3 addr_hi", req_addr_hi, 32'h0);
        chk("R3 wdata", req_wdata, wd);
        chk("R3 strb", {28'b0, req_strb}, 32'hF);
        handshake(s);
        chk("R3 valid drop", {31'b0, req_valid}, 32'h0);
        rd(6'h1C, v); chk("R5 busy start", v, 32'h1);
        complete(k, cs, cd);
        if (!kind[1]) exp_rd = cd;
        rd(6'h1C, v); chk("R5 start clear", v, 32'h0);
        rd(6'h20, v); chk("R5 isr set", v, 32'h1);
        rd(6'h04, v); chk("R5 status", v, {22'b0, cs, 7'b0});
        rd(6'h18, v); chk("R6 rdata", v, exp_rd);
        chk("R8 irq on", {31'b0, irq}, 32'h1);
        wr(6'h20, 32'h0); rd(6'h20, v); chk("R7 write0 noop", v, 32'h1);
        wr(6'h20, 32'h1); rd(6'h20, v); chk("R7 w1c", v, 32'h0);
        chk("R8 irq off", {31'b0, irq}, 32'h0);
      end
    end

    // R4 ignore restart while in flight
    setup(4'h8, 32'h0010_8004, 32'h0);
    wr(6'h1C, 32'h1);
    wr(6'h00, 32'hB);
    wr(6'h08, 32'h0FF0_0000);
    wr(6'h1C, 32'h1);
    chk("R4 kind held", {28'b0, req_kind}, 32'h8);
    chk("R4 addr held", req_addr_lo, 32'h0010_8004);
    handshake(0);
    complete(1, 3'h0, 32'h1111_2222);
    exp_rd = 32'h1111_2222;
    chk("R4 no second req", {31'b0, req_valid}, 32'h0);
    rd(6'h1C, v); chk("R4 idle", v, 32'h0);
    rd(6'h18, v); chk("R4 rdata", v, exp_rd);

    // R7 completion wins over clear; R8 mask
    wr(6'h00, 32'h9); wr(6'h1C, 32'h1); handshake(0);
    cpl_valid = 1'b1; cpl_status = 3'h2; cpl_data = 32'h3333_4444;
    csr_we = 1'b1; csr_addr = 6'h20; csr_wdata = 32'h1;
    @(negedge clk);
    cpl_valid = 1'b0; csr_we = 1'b0;
    exp_rd = 32'h3333_4444;
    rd(6'h20, v); chk("R7 set wins", v, 32'h1);
    wr(6'h24, 32'h1);
    chk("R8 masked", {31'b0, irq}, 32'h0);
    wr(6'h24, 32'h0);
    chk("R8 unmasked", {31'b0, irq}, 32'h1);
    wr(6'h20, 32'h1);

    // R9 abort in issue phase, then in wait phase, stray completion ignored
    wr(6'h1C, 32'h1);
    wr(6'h1C, 32'h0);
    chk("R9 valid low", {31'b0, req_valid}, 32'h0);
    rd(6'h1C, v); chk("R9 start low", v, 32'h0);
    wr(6'h1C, 32'h1); handshake(1);
    wr(6'h1C, 32'h0);
    complete(0, 3'h1, 32'h9999_9999);
    rd(6'h20, v); chk("R9 no done", v, 32'h0);
    rd(6'h18, v); chk("R9 rdata kept", v, exp_rd);

    // R10 timeout
    wr(6'h00, 32'hA);
    wr(6'h1C, 32'h1); handshake(2);
    repeat (TMO - 1) @(negedge clk);
    rd(6'h1C, v); chk("R10 still busy", v, 32'h1);
    @(negedge clk);
    rd(6'h1C, v); chk("R10 ended", v, 32'h0);
    rd(6'h20, v); chk("R10 done", v, 32'h1);
    rd(6'h04, v); chk("R10 status", v, {22'b0, 3'h7, 7'b0});
    rd(6'h18, v); chk("R10 rdata", v, 32'hFFFF_FFFF);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule